// File: doc/BRIEF.md
# Ten-bit address read sequencer

This block runs a complete read from a slave that answers to a 10-bit address. It sits above a byte-level bus engine that handles all bit timing. A host presents a 10-bit address and a byte count with a one-cycle `go` pulse. The sequencer then issues a fixed series of byte-level commands to the engine. It opens with a write phase that carries the full address but no data. A repeated start follows, resending only the first address byte with the read bit set. The block then reads the requested number of bytes and closes with a stop.

Each received byte leaves through a valid/ready port. The master acknowledges every byte except the last, which it answers with a not-acknowledge before the stop. If the slave refuses any address byte, the read is abandoned: the block sends a stop at once and reports the failure on a separate flag. A byte count of zero is refused before any bus activity.

Top module: `tenbit_rd_seq`

## Requirements
- R1: After `go` with a nonzero count, the first two commands are START (code 1) and WRITE (code 4). The WRITE carries the byte `{5'b11110, addr[9:8], 1'b0}`.
- R2: The third command is WRITE carrying `addr[7:0]`.
- R3: No STOP (code 3) is issued between the write phase and the read phase. The fourth command is RSTART (code 2), followed by WRITE carrying `{5'b11110, addr[9:8], 1'b1}`.
- R4: A count of N produces exactly N READ commands (code 5) and then one STOP. `eng_cmd_nack` is 0 on the first N-1 reads and 1 on the last.
- R5: Received bytes leave on `out_data` in the order they were read. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R6: If the engine reports a NACK on any of the three address bytes, the next command is STOP. After that STOP, no READ is issued, no byte is output, and `addr_nack` pulses for one cycle instead of `done`.
- R7: A `go` with a count of zero makes `len_err` pulse in the next cycle. No command is issued and `busy` stays low.
- R8: `busy` is high from the cycle after an accepted `go` until the cycle after the STOP handshake. A `go` that arrives while `busy` is high is ignored.
- R9: While `eng_cmd_valid` is high and `eng_cmd_ready` is low, the command, its data byte and its NACK bit stay unchanged.
- R10: A transfer in which all address bytes are acknowledged ends with a one-cycle `done` pulse in the cycle after the STOP handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, sampled while idle |
| addr | input | 10 | Slave 10-bit address |
| nbytes | input | CNT_W | Number of bytes to read |
| eng_cmd_valid | output | 1 | Command offered to the byte engine |
| eng_cmd_ready | input | 1 | Engine accepts the command |
| eng_cmd | output | 3 | Command code: 1 START, 2 RSTART, 3 STOP, 4 WRITE, 5 READ |
| eng_cmd_data | output | 8 | Byte to send for WRITE, 0 otherwise |
| eng_cmd_nack | output | 1 | For READ: master answers with NACK (1) or ACK (0) |
| eng_rsp_valid | input | 1 | Engine result for a WRITE or READ |
| eng_rsp_nack | input | 1 | Slave NACK on a WRITE |
| eng_rsp_data | input | 8 | Byte received on a READ |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse: transfer completed |
| addr_nack | output | 1 | One-cycle pulse: aborted on an address NACK |
| len_err | output | 1 | One-cycle pulse: zero byte count refused |

## Verification
The assertions check the handshake rules on every cycle:
- held commands and held output bytes stay stable;
- commands appear only while busy;
- the three status pulses are mutually exclusive and never coincide with `busy`.

Only the bench's scenarios can show the order and content of the command stream. That covers the address byte encodings, the absence of a stop before the repeated start, and the ACK/NACK pattern on the reads. The bench also shows the abort path for each address byte position and the byte order at the output.

// File: rtl/tenbit_rd_seq.sv
module tenbit_rd_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [9:0]       addr,
  input  logic [CNT_W-1:0] nbytes,
  output logic             eng_cmd_valid,
  input  logic             eng_cmd_ready,
  output logic [2:0]       eng_cmd,
  output logic [7:0]       eng_cmd_data,
  output logic             eng_cmd_nack,
  input  logic             eng_rsp_valid,
  input  logic             eng_rsp_nack,
  input  logic [7:0]       eng_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             busy,
  output logic             done,
  output logic             addr_nack,
  output logic             len_err
);
  localparam logic [2:0] C_START = 3'd1, C_RSTART = 3'd2, C_STOP = 3'd3,
                         C_WRITE = 3'd4, C_READ = 3'd5;
  localparam logic [4:0] HDR = 5'b11110;

  typedef enum logic [3:0] {
    IDLE, ST, A1W, A1W_W, A2, A2_W, RS, A1R, A1R_W, RD, RD_W, OUTB, SP
  } st_t;

  st_t              state;
  logic [9:0]       adr;
  logic [CNT_W-1:0] left;
  logic [7:0]       rbuf;
  logic             abort;

  assign busy      = (state != IDLE);
  assign out_valid = (state == OUTB);
  assign out_data  = rbuf;
  assign eng_cmd_valid = (state == ST) || (state == A1W) || (state == A2) ||
                         (state == RS) || (state == A1R) || (state == RD) ||
                         (state == SP);
  assign eng_cmd_nack = (state == RD) && (left == CNT_W'(1));

  always_comb begin
    eng_cmd      = 3'd0;
    eng_cmd_data = 8'h00;
    case (state)
      ST:  eng_cmd = C_START;
      A1W: begin eng_cmd = C_WRITE; eng_cmd_data = {HDR, adr[9:8], 1'b0}; end
      A2:  begin eng_cmd = C_WRITE; eng_cmd_data = adr[7:0]; end
      RS:  eng_cmd = C_RSTART;
      A1R: begin eng_cmd = C_WRITE; eng_cmd_data = {HDR, adr[9:8], 1'b1}; end
      RD:  eng_cmd = C_READ;
      SP:  eng_cmd = C_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      adr       <= '0;
      left      <= '0;
      rbuf      <= '0;
      abort     <= 1'b0;
      done      <= 1'b0;
      addr_nack <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      done      <= 1'b0;
      addr_nack <= 1'b0;
      len_err   <= 1'b0;
      case (state)
        IDLE: if (go) begin
          if (nbytes == '0) len_err <= 1'b1;
          else begin
            adr   <= addr;
            left  <= nbytes;
            abort <= 1'b0;
            state <= ST;
          end
        end
        ST:    if (eng_cmd_ready) state <= A1W;
        A1W:   if (eng_cmd_ready) state <= A1W_W;
        A1W_W: if (eng_rsp_valid) begin
          abort <= eng_rsp_nack;
          state <= eng_rsp_nack ? SP : A2;
        end
        A2:    if (eng_cmd_ready) state <= A2_W;
        A2_W:  if (eng_rsp_valid) begin
          abort <= eng_rsp_nack;
          state <= eng_rsp_nack ? SP : RS;
        end
        RS:    if (eng_cmd_ready) state <= A1R;
        A1R:   if (eng_cmd_ready) state <= A1R_W;
        A1R_W: if (eng_rsp_valid) begin
          abort <= eng_rsp_nack;
          state <= eng_rsp_nack ? SP : RD;
        end
        RD:    if (eng_cmd_ready) state <= RD_W;
        RD_W:  if (eng_rsp_valid) begin
          rbuf  <= eng_rsp_data;
          left  <= left - CNT_W'(1);
          state <= OUTB;
        end
        OUTB:  if (out_ready) state <= (left == '0) ? SP : RD;
        SP:    if (eng_cmd_ready) begin
          done      <= ~abort;
          addr_nack <= abort;
          state     <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module tenbit_rd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_cmd_valid,
  input logic       eng_cmd_ready,
  input logic [2:0] eng_cmd,
  input logic [7:0] eng_cmd_data,
  input logic       eng_cmd_nack,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       busy,
  input logic       done,
  input logic       addr_nack,
  input logic       len_err
);
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && !eng_cmd_ready |=>
      eng_cmd_valid && $stable(eng_cmd) && $stable(eng_cmd_data) && $stable(eng_cmd_nack));
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r8_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid |-> busy);
  a_r7_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !busy && !eng_cmd_valid);
  a_r6_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, addr_nack, len_err}));
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || addr_nack) |-> !busy);
  a_r4_stop_after: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_valid && eng_cmd_ready && eng_cmd == 3'd3 |=> !busy);
endmodule

bind tenbit_rd_seq tenbit_rd_seq_chk chk_i (.*);

// File: tb/tenbit_rd_seq_tb_top.sv
module tenbit_rd_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic go = 0;
  logic [9:0] addr = '0;
  logic [7:0] nbytes = '0;
  logic cmd_valid, cmd_ready = 0;
  logic [2:0] cmd;
  logic [7:0] cmd_data;
  logic cmd_nack;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_data = '0;
  logic out_valid, out_ready = 0;
  logic [7:0] out_data;
  logic busy, done, addr_nack, len_err;

  always #5 clk = ~clk;

  tenbit_rd_seq #(.CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .nbytes(nbytes),
    .eng_cmd_valid(cmd_valid), .eng_cmd_ready(cmd_ready), .eng_cmd(cmd),
    .eng_cmd_data(cmd_data), .eng_cmd_nack(cmd_nack),
    .eng_rsp_valid(rsp_valid), .eng_rsp_nack(rsp_nack), .eng_rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done), .addr_nack(addr_nack), .len_err(len_err));

  int total = 0, bad = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  int na, nr, wr_idx, rd_idx, np_cur;
  logic [2:0] a_cmd [32];
  logic [7:0] a_dat [32];
  logic       a_nk  [32];
  logic [7:0] rx    [32];
  int n_done, n_an, n_le, r9_bad, r5_bad, r8_bad, busy_seen;
  logic [9:0] cur_addr;
  logic [15:0] lfsr = 16'hACE1;
  bit pend, pend_rd, held, held_o;
  int dly;
  logic [2:0] h_cmd; logic [7:0] h_dat; logic h_nk; logic [7:0] h_out;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (held && (!cmd_valid || cmd != h_cmd || cmd_data != h_dat || cmd_nack != h_nk)) r9_bad++;
    if (held_o && (!out_valid || out_data != h_out)) r5_bad++;
    if (busy) busy_seen++;
    if (done) n_done++;
    if (addr_nack) n_an++;
    if (len_err) n_le++;
    rsp_valid = 0;
    if (pend) begin
      if (dly <= 1) begin
        rsp_valid = 1;
        pend = 0;
        if (pend_rd) begin
          rsp_data = cur_addr[7:0] + 8'(rd_idx * 29) + 8'd7;
          rsp_nack = 0;
          rd_idx++;
        end else begin
          rsp_nack = (wr_idx == np_cur);
          wr_idx++;
        end
      end else dly--;
    end
    cmd_ready = lfsr[0] | lfsr[3];
    out_ready = lfsr[5] | lfsr[7];
    held = cmd_valid && !cmd_ready;
    h_cmd = cmd; h_dat = cmd_data; h_nk = cmd_nack;
    held_o = out_valid && !out_ready;
    h_out = out_data;
    if (cmd_valid && cmd_ready) begin
      if (!busy) r8_bad++;
      if (na < 32) begin a_cmd[na] = cmd; a_dat[na] = cmd_data; a_nk[na] = cmd_nack; end
      na++;
      if (cmd == 3'd4 || cmd == 3'd5) begin
        pend = 1; pend_rd = (cmd == 3'd5); dly = 1 + int'(lfsr[2:1]);
      end
    end
    if (out_valid && out_ready) begin
      if (nr < 32) rx[nr] = out_data;
      nr++;
    end
  end

  logic [2:0] e_cmd [32];
  logic [7:0] e_dat [32];
  logic       e_nk  [32];
  string      e_tag [32];
  int ne;
  task automatic push(logic [2:0] c, logic [7:0] d, logic k, string t);
    e_cmd[ne] = c; e_dat[ne] = d; e_nk[ne] = k; e_tag[ne] = t; ne++;
  endtask

  task automatic run(logic [9:0] a, int n, int np, bit inject);
    int lim;
    ne = 0;
    push(3'd1, 8'h00, 0, "R1 start");
    push(3'd4, {5'b11110, a[9:8], 1'b0}, 0, "R1 hdr-w");
    if (np == 0) push(3'd3, 0, 0, "R6 stop");
    else begin
      push(3'd4, a[7:0], 0, "R2 low");
      if (np == 1) push(3'd3, 0, 0, "R6 stop");
      else begin
        push(3'd2, 0, 0, "R3 rstart");
        push(3'd4, {5'b11110, a[9:8], 1'b1}, 0, "R3 hdr-r");
        if (np == 2) push(3'd3, 0, 0, "R6 stop");
        else begin
          for (int i = 0; i < n; i++) push(3'd5, 0, (i == n - 1), "R4 read");
          push(3'd3, 0, 0, "R4 stop");
        end
      end
    end
    na = 0; nr = 0; wr_idx = 0; rd_idx = 0; np_cur = np; cur_addr = a;
    n_done = 0; n_an = 0; n_le = 0; r9_bad = 0; r5_bad = 0; r8_bad = 0;
    @(negedge clk);
    go = 1; addr = a; nbytes = 8'(n);
    @(negedge clk); #1;
    go = 0; addr = ~a;
    chk(busy == 1, "R8 busy after go", busy, 1);
    lim = 0;
    while (n_done + n_an == 0 && lim < 3000) begin
      @(negedge clk); #1;
      lim++;
      if (inject && lim == 4) begin go = 1; nbytes = 8'd7; end
      if (inject && lim == 5) go = 0;
    end
    chk(busy == 0, "R8 busy low after stop", busy, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(lim < 3000, "R10 watchdog", lim, 0);
    chk(na == ne, "R4 command count", na, ne);
    for (int i = 0; i < ne && i < na; i++) begin
      chk(a_cmd[i] == e_cmd[i], e_tag[i], a_cmd[i], e_cmd[i]);
      if (e_cmd[i] == 3'd4) chk(a_dat[i] == e_dat[i], e_tag[i], a_dat[i], e_dat[i]);
      if (e_cmd[i] == 3'd5) chk(a_nk[i] == e_nk[i], "R4 ack/nack", a_nk[i], e_nk[i]);
    end
    chk(nr == ((np == 3) ? n : 0), "R5/R6 byte count", nr, (np == 3) ? n : 0);
    if (np == 3)
      for (int i = 0; i < nr && i < 32; i++)
        chk(rx[i] == a[7:0] + 8'(i * 29) + 8'd7, "R5 byte value", rx[i], a[7:0] + 8'(i * 29) + 8'd7);
    chk(n_done == ((np == 3) ? 1 : 0), "R10 done", n_done, (np == 3) ? 1 : 0);
    chk(n_an == ((np == 3) ? 0 : 1), "R6 addr_nack", n_an, (np == 3) ? 0 : 1);
    chk(r9_bad == 0, "R9 held command", r9_bad, 0);
    chk(r5_bad == 0, "R5 held output", r5_bad, 0);
    chk(r8_bad == 0, "R8 busy at command", r8_bad, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL R8 global watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(busy == 0 && cmd_valid == 0, "R8 reset idle", {busy, cmd_valid}, 0);
    chk(out_valid == 0 && done == 0 && addr_nack == 0 && len_err == 0,
        "R10 reset flags", {out_valid, done, addr_nack, len_err}, 0);
    rst_n = 1;
    na = 0; n_le = 0; busy_seen = 0;
    @(negedge clk);
    go = 1; nbytes = 0; addr = 10'h2C3;
    @(negedge clk); #1;
    go = 0;
    chk(len_err == 1, "R7 len_err pulse", len_err, 1);
    repeat (4) @(negedge clk);
    #1;
    chk(na == 0, "R7 no command", na, 0);
    chk(busy_seen == 0, "R7 busy stayed low", busy_seen, 0);
    chk(n_le == 1, "R7 single pulse", n_le, 1);
    for (int hi = 0; hi < 4; hi++)
      for (int lo = 0; lo < 3; lo++)
        for (int n = 1; n <= 4; n++)
          for (int np = 0; np < 4; np++)
            run({2'(hi), (lo == 0) ? 8'h00 : (lo == 1) ? 8'hA5 : 8'hFF}, n, np, 0);
    run(10'h1E7, 3, 3, 1);
    run(10'h31C, 12, 3, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule